// File: doc/BRIEF.md
# Fault-Trip Shutdown Hold Controller

This block sits between a fast over-current trip, a shared active-low shutdown line and the gate-enable path of one or more half-bridge legs. When the trip input rises, every gate output drops in that same cycle, without waiting for the shared line to fall. On the next clock edge the block starts pulling the shared line low through an open-drain control. It keeps pulling until the synchronized copy of the line reads low. After that it lets go, and the external RC network on the line decides how long the legs stay disabled.

A low level on the line that comes from outside is never latched. The legs are disabled only while the synchronized line reads low, so a controller can chop the PWM through the line. Each leg takes a high-side and a low-side command, both active high. A leg drives only the side that is the sole one commanded, so a leg that is asked to turn on both sides keeps both off.

Top module: `fsd_shutdown_ctrl`

## Requirements
- R1: While rst_ni is low, pulldown_o, gate_en_o and every gate output are 0. The synchronizer flops reset to 0, so gate_en_o stays 0 after reset until a high line level has passed through the synchronizer.
- R2: In any cycle where trip_i is 1, gate_en_o and every bit of hs_gate_o and ls_gate_o are 0 in that same cycle.
- R3: pulldown_o is 1 in the cycle after any cycle in which trip_i was 1.
- R4: While pulldown_o is 1 and the synchronized line reads 1, pulldown_o stays 1. When pulldown_o is 1, the synchronized line reads 0 and trip_i is 0, pulldown_o is 0 from the next cycle on.
- R5: A trip that arrives while the pull-down is held only extends the hold. A trip that stays high keeps the pull-down on for as long as it lasts, even while the line reads low.
- R6: After the pull-down is released, gate_en_o stays 0 until the synchronized line reads 1, and then returns to 1.
- R7: A low driven onto sd_line_i from outside, with trip_i at 0, never asserts pulldown_o. gate_en_o is 0 only while the synchronized line reads 0.
- R8: sd_line_i passes through SYNC_STAGES flops. A change at the pin reaches gate_en_o exactly SYNC_STAGES clock edges later.
- R9: For each leg k, hs_gate_o[k] = gate_en_o & hi_cmd_i[k] & ~lo_cmd_i[k] and ls_gate_o[k] = gate_en_o & lo_cmd_i[k] & ~hi_cmd_i[k]. A leg with both commands at 1 drives both outputs to 0, and the two outputs of one leg are never 1 together.
- R10: Legs are independent. With commands held steady, each leg returns to its commanded state whenever gate_en_o returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trip_i | input | 1 | Synchronized comparator trip, active high |
| sd_line_i | input | 1 | Level read from the shared shutdown line, active low, asynchronous |
| hi_cmd_i | input | NUM_LEGS | High-side commands, one bit per leg |
| lo_cmd_i | input | NUM_LEGS | Low-side commands, one bit per leg |
| gate_en_o | output | 1 | Common gate enable |
| pulldown_o | output | 1 | Open-drain pull-down control for the shutdown line |
| hs_gate_o | output | NUM_LEGS | High-side gate outputs |
| ls_gate_o | output | NUM_LEGS | Low-side gate outputs |

## Verification
The bench builds the block with NUM_LEGS = 3 and SYNC_STAGES = 3. Three legs let one shared enable be checked against different command mixes at once, including a leg that commands both sides. The three-stage synchronizer widens the gap between the trip path, which acts in the same cycle, and the line path, which lags. That gap makes the hold visible while the line still reads high, and it shows how long the release waits. Trip pulses are applied before the hold, during the hold and while the line is already low.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  typedef enum logic {
    FSD_RUN  = 1'b0,
    FSD_HOLD = 1'b1
  } fsd_state_e;
endpackage

// File: rtl/fsd_line_sync.sv
module fsd_line_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RESET_VAL}};
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/fsd_hold_ctrl.sv
module fsd_hold_ctrl
  import fsd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic line_s_i,
  output logic pulldown_o,
  output logic gate_en_o
);
  fsd_state_e state_q, state_d;

  always_comb begin
    state_d = FSD_RUN;
    if (trip_i) state_d = FSD_HOLD;
    else if (state_q == FSD_HOLD && line_s_i) state_d = FSD_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FSD_RUN;
    else         state_q <= state_d;
  end

  assign pulldown_o = (state_q == FSD_HOLD);
  // trip bypasses the line: kills enable in the same cycle
  assign gate_en_o  = ~trip_i & ~pulldown_o & line_s_i;
endmodule

// File: rtl/fsd_leg_gate.sv
module fsd_leg_gate (
  input  logic en_i,
  input  logic hi_i,
  input  logic lo_i,
  output logic hs_o,
  output logic ls_o
);
  logic both_w;

  assign both_w = hi_i & lo_i;
  assign hs_o   = en_i & hi_i & ~both_w;
  assign ls_o   = en_i & lo_i & ~both_w;
endmodule

// File: rtl/fsd_shutdown_ctrl.sv
module fsd_shutdown_ctrl #(
  parameter int unsigned NUM_LEGS    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                trip_i,
  input  logic                sd_line_i,
  input  logic [NUM_LEGS-1:0] hi_cmd_i,
  input  logic [NUM_LEGS-1:0] lo_cmd_i,
  output logic                gate_en_o,
  output logic                pulldown_o,
  output logic [NUM_LEGS-1:0] hs_gate_o,
  output logic [NUM_LEGS-1:0] ls_gate_o
);
  logic line_s;

  fsd_line_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b0)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sd_line_i),
    .q_o   (line_s)
  );

  fsd_hold_ctrl u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trip_i    (trip_i),
    .line_s_i  (line_s),
    .pulldown_o(pulldown_o),
    .gate_en_o (gate_en_o)
  );

  for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
    fsd_leg_gate u_leg (
      .en_i(gate_en_o),
      .hi_i(hi_cmd_i[k]),
      .lo_i(lo_cmd_i[k]),
      .hs_o(hs_gate_o[k]),
      .ls_o(ls_gate_o[k])
    );
  end
endmodule

// File: rtl/fsd_shutdown_checker.sv
module fsd_shutdown_checker #(
  parameter int unsigned NUM_LEGS = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                trip_i,
  input logic                line_s,
  input logic                gate_en_o,
  input logic                pulldown_o,
  input logic [NUM_LEGS-1:0] hs_gate_o,
  input logic [NUM_LEGS-1:0] ls_gate_o
);
  p_trip_kills_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_i |-> (!gate_en_o && hs_gate_o == '0 && ls_gate_o == '0));

  p_pd_on_trip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_i |=> pulldown_o);

  p_pd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulldown_o && line_s) |=> pulldown_o);

  p_pd_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulldown_o && !line_s && !trip_i) |=> !pulldown_o);

  p_en_needs_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en_o |-> (line_s && !pulldown_o));

  p_no_pd_without_trip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulldown_o && !trip_i) |=> !pulldown_o);

  p_no_shoot_through_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_gate_o & ls_gate_o) == '0);

  p_outputs_need_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_en_o |-> (hs_gate_o == '0 && ls_gate_o == '0));
endmodule

bind fsd_shutdown_ctrl fsd_shutdown_checker #(.NUM_LEGS(NUM_LEGS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .trip_i    (trip_i),
  .line_s    (line_s),
  .gate_en_o (gate_en_o),
  .pulldown_o(pulldown_o),
  .hs_gate_o (hs_gate_o),
  .ls_gate_o (ls_gate_o)
);

// File: tb/fsd_shutdown_ctrl_tb_top.sv
`timescale 1ns/1ps
module fsd_shutdown_ctrl_tb_top;
  localparam int NL = 3;
  localparam int SS = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          trip_i = 1'b0;
  logic          sd_line_i = 1'b1;
  logic [NL-1:0] hi_cmd_i = '0;
  logic [NL-1:0] lo_cmd_i = '0;
  logic          gate_en_o, pulldown_o;
  logic [NL-1:0] hs_gate_o, ls_gate_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  always #4 clk_i = ~clk_i;

  fsd_shutdown_ctrl #(.NUM_LEGS(NL), .SYNC_STAGES(SS)) dut_i (.*);

  // reference model
  bit pipe_m[$];
  bit hold_m;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_m = {};
      for (int i = 0; i < SS; i++) pipe_m.push_back(1'b0);
      hold_m = 1'b0;
    end else begin
      hold_m = trip_i || (hold_m && pipe_m[0]);
      pipe_m.push_back(sd_line_i);
      void'(pipe_m.pop_front());
    end
  end

  task automatic cmp(string tag, string what, logic [NL-1:0] act, logic [NL-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit trip, bit line, logic [NL-1:0] hi, logic [NL-1:0] lo);
    bit en_e;
    logic [NL-1:0] hs_e, ls_e;
    @(negedge clk_i);
    trip_i = trip; sd_line_i = line; hi_cmd_i = hi; lo_cmd_i = lo;
    #1;
    en_e = rst_ni && !trip && !hold_m && pipe_m[0];
    hs_e = '0; ls_e = '0;
    for (int k = 0; k < NL; k++) begin
      hs_e[k] = en_e && hi[k] && !lo[k];
      ls_e[k] = en_e && lo[k] && !hi[k];
    end
    cmp(tag, "gate_en", NL'(gate_en_o), NL'(en_e));
    cmp(tag, "pulldown", NL'(pulldown_o), NL'(hold_m));
    cmp(tag, "hs_gate", hs_gate_o, hs_e);
    cmp(tag, "ls_gate", ls_gate_o, ls_e);
  endtask

  initial begin
    // R1 reset state
    for (int i = 0; i < 3; i++) step("R1", 0, 1, 3'b001, 3'b010);
    @(negedge clk_i); rst_ni = 1'b1;
    // R8 line reaches enable after SS edges; R9 leg decode
    for (int i = 0; i < 6; i++) step("R8", 0, 1, 3'b001, 3'b010);
    step("R9", 0, 1, 3'b101, 3'b010);
    step("R9", 0, 1, 3'b111, 3'b111);
    step("R9", 0, 1, 3'b110, 3'b011);
    // R7/R10 chopping through the line, commands steady
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 4; i++) step("R7", 0, 0, 3'b100, 3'b011);
      for (int i = 0; i < 5; i++) step("R10", 0, 1, 3'b100, 3'b011);
    end
    // R2/R3 trip with line still high
    step("R2", 1, 1, 3'b011, 3'b100);
    for (int i = 0; i < 3; i++) step("R4", 0, 1, 3'b011, 3'b100);
    // R5 trip during hold
    step("R5", 1, 1, 3'b011, 3'b100);
    for (int i = 0; i < 2; i++) step("R5", 0, 1, 3'b011, 3'b100);
    // R4 release once line reads low, R6 stays off
    for (int i = 0; i < 6; i++) step("R6", 0, 0, 3'b011, 3'b100);
    for (int i = 0; i < 5; i++) step("R6", 0, 1, 3'b011, 3'b100);
    // R5 persistent trip while line low
    for (int i = 0; i < 3; i++) step("R5", 1, 1, 3'b001, 3'b100);
    for (int i = 0; i < 4; i++) step("R5", 1, 0, 3'b001, 3'b100);
    for (int i = 0; i < 4; i++) step("R4", 0, 0, 3'b001, 3'b100);
    for (int i = 0; i < 5; i++) step("R6", 0, 1, 3'b001, 3'b100);
    // R3 single-cycle trip with line low from outside
    for (int i = 0; i < 4; i++) step("R7", 0, 0, 3'b010, 3'b001);
    step("R3", 1, 0, 3'b010, 3'b001);
    for (int i = 0; i < 3; i++) step("R4", 0, 0, 3'b010, 3'b001);
    for (int i = 0; i < 5; i++) step("R10", 0, 1, 3'b010, 3'b001);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule